// File: doc/BRIEF.md
# Clock and Power Mode Sequencer

This block is the state controller that decides how a small processor system is clocked. Software sends it decoded requests: standby entries, moves between the fast and slow run modes, PLL power and selection writes, and gear (divider) writes. Oscillator and PLL ready flags and a wake-up interrupt come back in as inputs. From these the block drives the oscillator and PLL enables, the system clock source select, the divider setting as a power of two, and clock gates for the CPU domain and the peripheral I/O domain. The oscillators, the PLL and the glitch-free clock switch sit outside the block and are seen only through enable and ready signals.

Three build-time topologies are offered. The first has one fast oscillator. The second adds a slow oscillator and a SLOW run mode. The third adds a PLL that multiplies the fast oscillator by four. Each topology has its own set of legal transitions. A request that the current state does not allow leaves everything unchanged and raises an error pulse for one cycle. PLL shutdown must be done in order: first select away from the PLL, then switch the PLL off. STOP cannot be entered while the PLL is powered.

The divider output gives the system clock as source / 2^div_shift. The PLL source is already four times the fast oscillator. Mode codes: NORMAL=0, SLOW=1, IDLE2=2, IDLE1=3, STOP=4. Source codes: fast oscillator=0, slow oscillator=1, PLL=2. Request codes on `req_op`: 1 go SLOW, 2 go NORMAL, 3 enter IDLE2, 4 enter IDLE1, 5 enter STOP, 6 PLL on, 7 PLL off, 8 select PLL, 9 select oscillator, 10 gear write (code on `req_arg`). Codes 0 and 11 to 15 are illegal.

Top module: `cpm_seq`

## Requirements
- R1: After reset the block is in NORMAL (mode 0) with source 0, div_shift 5 (fast oscillator / 32), hosc_en 1, pll_en 0, both clock gates on and err_pulse 0.
- R2: In NORMAL, a gear write (op 10) with code g in 0..4 gives div_shift g+1. Codes 5 to 7 give div_shift 1, which is the divide-by-1 gear followed by the fixed /2. The new value shows in the cycle after the request.
- R3: Go SLOW (op 1) from NORMAL with the PLL off waits until losc_ready is sampled high, then shows mode 1 with source 1 and div_shift 1. Go NORMAL (op 2) from SLOW raises hosc_en and waits for hosc_ready. The single-oscillator topology rejects op 1.
- R4: IDLE2 (mode 2) gates the CPU clock off and keeps the I/O clock on. IDLE1 (mode 3) gates both off. STOP (mode 4) gates both off and drops all oscillator and PLL enables.
- R5: A wake interrupt in IDLE1 or IDLE2 returns to the run mode the standby was entered from, in the next cycle. In STOP it first raises the enable of that run mode's oscillator and holds mode 4 until the matching ready flag is sampled high.
- R6: A STOP request (op 5) while pll_en is 1 is rejected.
- R7: PLL off (op 7) while the PLL is the selected source is rejected. After select oscillator (op 9) it is accepted and pll_en falls.
- R8: In SLOW, the PLL requests (ops 6 to 9) are ignored: no state change and no error.
- R9: Select PLL (op 8) needs pll_en 1. The source output becomes 2 only after pll_ready has been sampled high.
- R10: An illegal request leaves the mode unchanged and raises err_pulse for exactly the following cycle. Illegal requests are: an unknown code, any request while in IDLE1, IDLE2 or STOP, any request while a clock switch is waiting, and a PLL request in a topology without a PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Request code |
| req_arg | input | 3 | Gear code for op 10 |
| wake_irq | input | 1 | Wake-up interrupt |
| hosc_ready | input | 1 | Fast oscillator is stable |
| losc_ready | input | 1 | Slow oscillator is stable |
| pll_ready | input | 1 | PLL is locked |
| mode_o | output | 3 | Current operating mode |
| hosc_en | output | 1 | Fast oscillator enable |
| losc_en | output | 1 | Slow oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_src | output | 2 | System clock source select |
| div_shift | output | DIV_W (3) | System clock = source / 2^div_shift |
| cpu_clk_en | output | 1 | CPU clock domain gate |
| io_clk_en | output | 1 | Peripheral I/O clock domain gate |
| err_pulse | output | 1 | One-cycle flag for a rejected request |

## Verification
The bench builds the block three times side by side, with TOPOLOGY 0, 1 and 2, and drives all three with the same request and wake stream. This lets one stimulus exercise each topology's own rejections. For example, a go-SLOW request is legal in the dual and triple builds but is an error in the single build, and PLL requests are errors everywhere except the triple build. The default gear width and RESET_GEAR of 4 expose the /32 reset divider and every gear code, including the unused ones. The bench's ready models make each oscillator stable three cycles after its enable, so the waits on a clock switch and on a STOP wake-up are visible as held mode outputs.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

   localparam int GEAR_W = 3;
   localparam int OP_W   = 4;

   typedef enum logic [2:0] {
      M_NORMAL = 3'd0,
      M_SLOW   = 3'd1,
      M_IDLE2  = 3'd2,
      M_IDLE1  = 3'd3,
      M_STOP   = 3'd4
   } mode_e;

   typedef enum logic [2:0] {
      P_NONE    = 3'd0,
      P_TO_SLOW = 3'd1,
      P_TO_NORM = 3'd2,
      P_PLL_SEL = 3'd3,
      P_WAKE    = 3'd4
   } pend_e;

   typedef enum logic [1:0] {
      SRC_HI  = 2'd0,
      SRC_LO  = 2'd1,
      SRC_PLL = 2'd2
   } src_e;

   localparam logic [OP_W-1:0] OP_TO_SLOW  = 4'd1;
   localparam logic [OP_W-1:0] OP_TO_NORM  = 4'd2;
   localparam logic [OP_W-1:0] OP_IDLE2    = 4'd3;
   localparam logic [OP_W-1:0] OP_IDLE1    = 4'd4;
   localparam logic [OP_W-1:0] OP_STOP     = 4'd5;
   localparam logic [OP_W-1:0] OP_PLL_ON   = 4'd6;
   localparam logic [OP_W-1:0] OP_PLL_OFF  = 4'd7;
   localparam logic [OP_W-1:0] OP_SEL_PLL  = 4'd8;
   localparam logic [OP_W-1:0] OP_SEL_OSC  = 4'd9;
   localparam logic [OP_W-1:0] OP_GEAR     = 4'd10;

   typedef struct packed {
      mode_e             mode;
      mode_e             ret;
      pend_e             pend;
      logic              pll_on;
      logic              pll_sel;
      logic [GEAR_W-1:0] gear;
   } seq_state_t;

endpackage

// File: rtl/cpm_gear_dec.sv
module cpm_gear_dec #(
   parameter int GW      = 3,
   parameter int MAX_LOG = 4,
   parameter int OUT_W   = 3
) (
   input  logic [GW-1:0]    code,
   output logic [OUT_W-1:0] shift
);
   localparam int N_GEARS = MAX_LOG + 1;

   if (N_GEARS > (1 << GW)) begin : g_bad_gw
      $error("cpm_gear_dec: gear field too narrow for MAX_LOG");
   end
   if (MAX_LOG + 1 >= (1 << OUT_W)) begin : g_bad_ow
      $error("cpm_gear_dec: output too narrow");
   end

   logic [N_GEARS-1:0] hit;

   for (genvar i = 0; i < N_GEARS; i++) begin : g_hit
      assign hit[i] = (code == GW'(i));
   end

   // Unused codes fall through to shift 0 (divide-by-1).
   always_comb begin
      shift = '0;
      for (int i = 0; i < N_GEARS; i++) begin
         if (hit[i]) shift = OUT_W'(i);
      end
   end

endmodule

// File: rtl/cpm_rules.sv
module cpm_rules
   import cpm_pkg::*;
#(
   parameter bit HAS_LO  = 1'b1,
   parameter bit HAS_PLL = 1'b1
) (
   input  seq_state_t        cur,
   input  logic              req_valid,
   input  logic [OP_W-1:0]   req_op,
   input  logic [GEAR_W-1:0] req_arg,
   input  logic              wake_irq,
   input  logic              hosc_ready,
   input  logic              losc_ready,
   input  logic              pll_ready,
   output seq_state_t        nxt,
   output logic              reject
);
   logic running, in_slow, idle_any, waiting, wake_rdy;

   assign running  = (cur.mode == M_NORMAL) || (cur.mode == M_SLOW);
   assign in_slow  = (cur.mode == M_SLOW);
   assign idle_any = (cur.mode == M_IDLE1) || (cur.mode == M_IDLE2);
   assign waiting  = (cur.pend != P_NONE);
   assign wake_rdy = (cur.ret == M_SLOW) ? losc_ready : hosc_ready;

   always_comb begin
      nxt    = cur;
      reject = 1'b0;

      // Completion of a clock switch in progress
      unique case (cur.pend)
         P_TO_SLOW: if (losc_ready) begin
            nxt.mode = M_SLOW;
            nxt.pend = P_NONE;
         end
         P_TO_NORM: if (hosc_ready) begin
            nxt.mode = M_NORMAL;
            nxt.pend = P_NONE;
         end
         P_PLL_SEL: if (pll_ready) begin
            nxt.pll_sel = 1'b1;
            nxt.pend    = P_NONE;
         end
         P_WAKE: if (wake_rdy) begin
            nxt.mode = cur.ret;
            nxt.pend = P_NONE;
         end
         default: ;
      endcase

      // Wake-up
      if (wake_irq && idle_any) nxt.mode = cur.ret;
      if (wake_irq && (cur.mode == M_STOP) && !waiting) nxt.pend = P_WAKE;

      // Software requests
      if (req_valid) begin
         if (!running || waiting) begin
            reject = 1'b1;
         end else begin
            case (req_op)
               OP_TO_SLOW: begin
                  if (!HAS_LO || (!in_slow && cur.pll_on)) reject = 1'b1;
                  else if (!in_slow) nxt.pend = P_TO_SLOW;
               end
               OP_TO_NORM: if (in_slow) nxt.pend = P_TO_NORM;
               OP_IDLE2: begin
                  nxt.ret  = cur.mode;
                  nxt.mode = M_IDLE2;
               end
               OP_IDLE1: begin
                  nxt.ret  = cur.mode;
                  nxt.mode = M_IDLE1;
               end
               OP_STOP: begin
                  if (cur.pll_on) reject = 1'b1;
                  else begin
                     nxt.ret  = cur.mode;
                     nxt.mode = M_STOP;
                  end
               end
               OP_PLL_ON: begin
                  if (!HAS_PLL) reject = 1'b1;
                  else if (!in_slow) nxt.pll_on = 1'b1;
               end
               OP_PLL_OFF: begin
                  if (!HAS_PLL) reject = 1'b1;
                  else if (!in_slow) begin
                     if (cur.pll_sel) reject = 1'b1;
                     else nxt.pll_on = 1'b0;
                  end
               end
               OP_SEL_PLL: begin
                  if (!HAS_PLL) reject = 1'b1;
                  else if (!in_slow) begin
                     if (!cur.pll_on) reject = 1'b1;
                     else if (!cur.pll_sel) nxt.pend = P_PLL_SEL;
                  end
               end
               OP_SEL_OSC: begin
                  if (!HAS_PLL) reject = 1'b1;
                  else if (!in_slow) nxt.pll_sel = 1'b0;
               end
               OP_GEAR: nxt.gear = req_arg;
               default: reject = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/cpm_clk_map.sv
module cpm_clk_map
   import cpm_pkg::*;
#(
   parameter bit HAS_LO  = 1'b1,
   parameter bit HAS_PLL = 1'b1,
   parameter int DIV_W   = 3
) (
   input  mode_e            mode,
   input  mode_e            ret,
   input  pend_e            pend,
   input  logic             pll_on,
   input  logic             pll_sel,
   input  logic [DIV_W-1:0] gear_shift,
   output logic             hosc_en,
   output logic             losc_en,
   output logic             pll_en,
   output logic [1:0]       clk_src,
   output logic [DIV_W-1:0] div_shift,
   output logic             cpu_clk_en,
   output logic             io_clk_en
);
   logic  stopped, base_slow;
   mode_e base;

   assign stopped   = (mode == M_STOP);
   assign base      = ((mode == M_NORMAL) || (mode == M_SLOW)) ? mode : ret;
   assign base_slow = (base == M_SLOW);

   assign hosc_en = (!stopped && (base == M_NORMAL))
                  || (pend == P_TO_NORM)
                  || (stopped && (pend == P_WAKE) && (ret == M_NORMAL));

   if (HAS_LO) begin : g_lo
      assign losc_en = !stopped || ((pend == P_WAKE) && (ret == M_SLOW));
   end else begin : g_no_lo
      assign losc_en = 1'b0;
   end

   if (HAS_PLL) begin : g_pll
      assign pll_en  = pll_on;
      assign clk_src = base_slow ? SRC_LO : (pll_sel ? SRC_PLL : SRC_HI);
   end else begin : g_no_pll
      assign pll_en  = 1'b0;
      assign clk_src = base_slow ? SRC_LO : SRC_HI;
   end

   // SLOW is always the slow oscillator / 2; otherwise gear then / 2
   assign div_shift  = base_slow ? DIV_W'(1) : gear_shift + DIV_W'(1);
   assign cpu_clk_en = (mode == M_NORMAL) || (mode == M_SLOW);
   assign io_clk_en  = cpu_clk_en || (mode == M_IDLE2);

endmodule

// File: rtl/cpm_seq.sv
module cpm_seq
   import cpm_pkg::*;
#(
   parameter int TOPOLOGY   = 2,
   parameter int DIV_W      = 3,
   parameter int MAX_LOG    = 4,
   parameter int RESET_GEAR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OP_W-1:0]   req_op,
   input  logic [GEAR_W-1:0] req_arg,
   input  logic              wake_irq,
   input  logic              hosc_ready,
   input  logic              losc_ready,
   input  logic              pll_ready,
   output logic [2:0]        mode_o,
   output logic              hosc_en,
   output logic              losc_en,
   output logic              pll_en,
   output logic [1:0]        clk_src,
   output logic [DIV_W-1:0]  div_shift,
   output logic              cpu_clk_en,
   output logic              io_clk_en,
   output logic              err_pulse
);
   localparam bit HAS_LO  = (TOPOLOGY >= 1);
   localparam bit HAS_PLL = (TOPOLOGY >= 2);

   if (TOPOLOGY < 0 || TOPOLOGY > 2) begin : g_bad_topo
      $error("cpm_seq: TOPOLOGY must be 0, 1 or 2");
   end
   if (RESET_GEAR > MAX_LOG) begin : g_bad_rg
      $error("cpm_seq: RESET_GEAR beyond MAX_LOG");
   end

   seq_state_t        st_q, st_d;
   logic              rej;
   logic [DIV_W-1:0]  gear_shift;

   cpm_rules #(.HAS_LO(HAS_LO), .HAS_PLL(HAS_PLL)) u_rules (
      .cur       (st_q),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_arg   (req_arg),
      .wake_irq  (wake_irq),
      .hosc_ready(hosc_ready),
      .losc_ready(losc_ready),
      .pll_ready (pll_ready),
      .nxt       (st_d),
      .reject    (rej)
   );

   cpm_gear_dec #(.GW(GEAR_W), .MAX_LOG(MAX_LOG), .OUT_W(DIV_W)) u_gear (
      .code (st_q.gear),
      .shift(gear_shift)
   );

   cpm_clk_map #(.HAS_LO(HAS_LO), .HAS_PLL(HAS_PLL), .DIV_W(DIV_W)) u_map (
      .mode      (st_q.mode),
      .ret       (st_q.ret),
      .pend      (st_q.pend),
      .pll_on    (st_q.pll_on),
      .pll_sel   (st_q.pll_sel),
      .gear_shift(gear_shift),
      .hosc_en   (hosc_en),
      .losc_en   (losc_en),
      .pll_en    (pll_en),
      .clk_src   (clk_src),
      .div_shift (div_shift),
      .cpu_clk_en(cpu_clk_en),
      .io_clk_en (io_clk_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q.mode    <= M_NORMAL;
         st_q.ret     <= M_NORMAL;
         st_q.pend    <= P_NONE;
         st_q.pll_on  <= 1'b0;
         st_q.pll_sel <= 1'b0;
         st_q.gear    <= GEAR_W'(RESET_GEAR);
         err_pulse    <= 1'b0;
      end else begin
         st_q      <= st_d;
         err_pulse <= rej;
      end
   end

   assign mode_o = st_q.mode;

   // R10: an error flag always follows a request
   a_r10_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(req_valid));

   // R4: settled STOP has every source powered down
   a_r4_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_STOP && st_q.pend == P_NONE) |-> (!hosc_en && !losc_en && !pll_en));

   // R6: STOP never coexists with a powered PLL
   a_r6_stop_no_pll: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_STOP) |-> !pll_en);

   // R7: the PLL is never off while selected
   a_r7_sel_implies_on: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_src == SRC_PLL) |-> pll_en);

   // R9: switching onto the PLL follows a sampled lock
   a_r9_pll_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_src == SRC_PLL) && $past(mode_o == M_NORMAL) |-> $past(pll_ready));

   // R5: leaving STOP follows a sampled oscillator ready
   a_r5_stop_exit_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_o == M_STOP) |-> $past(hosc_ready || losc_ready));

   // R3: NORMAL to SLOW follows a sampled slow-oscillator ready
   a_r3_slow_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o == M_SLOW) && $past(mode_o == M_NORMAL) |-> $past(losc_ready));

   // R8: PLL power is steady throughout SLOW
   a_r8_slow_pll_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_SLOW) && $past(mode_o == M_SLOW) |-> $stable(pll_en));

endmodule

// File: tb/cpm_seq_tb.sv
module cpm_seq_tb;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       req_valid;
   logic [3:0] req_op;
   logic [2:0] req_arg;
   logic       wake;

   logic [2:0] o_mode [3];
   logic       o_hen [3], o_len [3], o_pen [3], o_cpu [3], o_io [3], o_err [3];
   logic [1:0] o_src [3];
   logic [2:0] o_div [3];
   logic       r_h [3], r_l [3], r_p [3];

   cpm_seq #(.TOPOLOGY(0)) u_single (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_arg(req_arg),
      .wake_irq(wake), .hosc_ready(r_h[0]), .losc_ready(r_l[0]), .pll_ready(r_p[0]),
      .mode_o(o_mode[0]), .hosc_en(o_hen[0]), .losc_en(o_len[0]), .pll_en(o_pen[0]),
      .clk_src(o_src[0]), .div_shift(o_div[0]), .cpu_clk_en(o_cpu[0]), .io_clk_en(o_io[0]),
      .err_pulse(o_err[0]));

   cpm_seq #(.TOPOLOGY(1)) u_dual (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_arg(req_arg),
      .wake_irq(wake), .hosc_ready(r_h[1]), .losc_ready(r_l[1]), .pll_ready(r_p[1]),
      .mode_o(o_mode[1]), .hosc_en(o_hen[1]), .losc_en(o_len[1]), .pll_en(o_pen[1]),
      .clk_src(o_src[1]), .div_shift(o_div[1]), .cpu_clk_en(o_cpu[1]), .io_clk_en(o_io[1]),
      .err_pulse(o_err[1]));

   cpm_seq #(.TOPOLOGY(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_arg(req_arg),
      .wake_irq(wake), .hosc_ready(r_h[2]), .losc_ready(r_l[2]), .pll_ready(r_p[2]),
      .mode_o(o_mode[2]), .hosc_en(o_hen[2]), .losc_en(o_len[2]), .pll_en(o_pen[2]),
      .clk_src(o_src[2]), .div_shift(o_div[2]), .cpu_clk_en(o_cpu[2]), .io_clk_en(o_io[2]),
      .err_pulse(o_err[2]));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   // Reference model state, one slot per topology
   int mm [3], mret [3], mpend [3], mpll [3], msel [3], mgear [3], merr [3];
   int ch [3], cl [3], cp [3];

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   function automatic int base_of(int t);
      return (mm[t] <= 1) ? mm[t] : mret[t];
   endfunction

   function automatic int e_hen(int t);
      return ((mm[t] != 4 && base_of(t) == 0) || mpend[t] == 2 ||
              (mm[t] == 4 && mpend[t] == 4 && mret[t] == 0)) ? 1 : 0;
   endfunction

   function automatic int e_len(int t);
      if (t == 0) return 0;
      return (mm[t] != 4 || (mpend[t] == 4 && mret[t] == 1)) ? 1 : 0;
   endfunction

   function automatic int e_src(int t);
      if (base_of(t) == 1) return 1;
      return msel[t] ? 2 : 0;
   endfunction

   function automatic int e_div(int t);
      if (base_of(t) == 1) return 1;
      return ((mgear[t] <= 4) ? mgear[t] : 0) + 1;
   endfunction

   task automatic model_reset();
      for (int t = 0; t < 3; t++) begin
         mm[t] = 0; mret[t] = 0; mpend[t] = 0; mpll[t] = 0;
         msel[t] = 0; mgear[t] = 4; merr[t] = 0;
      end
   endtask

   task automatic model_step(int t);
      int nm, nr, np, npl, ns, ng, e;
      bit has_lo, has_pll, run, slow, rdy;
      nm = mm[t]; nr = mret[t]; np = mpend[t]; npl = mpll[t]; ns = msel[t]; ng = mgear[t]; e = 0;
      has_lo = (t >= 1); has_pll = (t == 2);
      run = (mm[t] <= 1); slow = (mm[t] == 1);
      if (mpend[t] == 1 && r_l[t]) begin nm = 1; np = 0; end
      if (mpend[t] == 2 && r_h[t]) begin nm = 0; np = 0; end
      if (mpend[t] == 3 && r_p[t]) begin ns = 1; np = 0; end
      if (mpend[t] == 4) begin
         rdy = (mret[t] == 1) ? r_l[t] : r_h[t];
         if (rdy) begin nm = mret[t]; np = 0; end
      end
      if (wake && (mm[t] == 2 || mm[t] == 3)) nm = mret[t];
      if (wake && mm[t] == 4 && mpend[t] == 0) np = 4;
      if (req_valid) begin
         if (!run || mpend[t] != 0) e = 1;
         else begin
            case (int'(req_op))
               1: if (!has_lo || (!slow && mpll[t] != 0)) e = 1; else if (!slow) np = 1;
               2: if (slow) np = 2;
               3: begin nr = mm[t]; nm = 2; end
               4: begin nr = mm[t]; nm = 3; end
               5: if (mpll[t] != 0) e = 1; else begin nr = mm[t]; nm = 4; end
               6: if (!has_pll) e = 1; else if (!slow) npl = 1;
               7: if (!has_pll) e = 1; else if (!slow) begin
                     if (msel[t] != 0) e = 1; else npl = 0;
                  end
               8: if (!has_pll) e = 1; else if (!slow) begin
                     if (mpll[t] == 0) e = 1; else if (msel[t] == 0) np = 3;
                  end
               9: if (!has_pll) e = 1; else if (!slow) ns = 0;
               10: ng = int'(req_arg);
               default: e = 1;
            endcase
         end
      end
      mm[t] = nm; mret[t] = nr; mpend[t] = np; mpll[t] = npl; msel[t] = ns; mgear[t] = ng; merr[t] = e;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else for (int t = 0; t < 3; t++) model_step(t);
   end

   // Per-cycle comparison, then the oscillator ready models
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int t = 0; t < 3; t++) begin
            chk("R5", $sformatf("mode[%0d]", t), int'(o_mode[t]), mm[t]);
            chk("R4", $sformatf("hosc_en[%0d]", t), int'(o_hen[t]), e_hen(t));
            chk("R4", $sformatf("losc_en[%0d]", t), int'(o_len[t]), e_len(t));
            chk("R7", $sformatf("pll_en[%0d]", t), int'(o_pen[t]), (t == 2) ? mpll[t] : 0);
            chk("R9", $sformatf("clk_src[%0d]", t), int'(o_src[t]), e_src(t));
            chk("R2", $sformatf("div_shift[%0d]", t), int'(o_div[t]), e_div(t));
            chk("R4", $sformatf("cpu_clk_en[%0d]", t), int'(o_cpu[t]), (mm[t] <= 1) ? 1 : 0);
            chk("R4", $sformatf("io_clk_en[%0d]", t), int'(o_io[t]), (mm[t] <= 2) ? 1 : 0);
            chk("R10", $sformatf("err_pulse[%0d]", t), int'(o_err[t]), merr[t]);
         end
      end
      for (int t = 0; t < 3; t++) begin
         ch[t] = (rst_n && o_hen[t]) ? ((ch[t] < 3) ? ch[t] + 1 : 3) : 0;
         cl[t] = (rst_n && o_len[t]) ? ((cl[t] < 3) ? cl[t] + 1 : 3) : 0;
         cp[t] = (rst_n && o_pen[t]) ? ((cp[t] < 3) ? cp[t] + 1 : 3) : 0;
         r_h[t] = (ch[t] >= 3);
         r_l[t] = (cl[t] >= 3);
         r_p[t] = (cp[t] >= 3);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic req(int op, int arg);
      @(negedge clk);
      req_valid = 1'b1; req_op = 4'(op); req_arg = 3'(arg);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wk();
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      for (int t = 0; t < 3; t++) begin
         ch[t] = 0; cl[t] = 0; cp[t] = 0; r_h[t] = 0; r_l[t] = 0; r_p[t] = 0;
      end
      model_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_arg = '0; wake = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(4);

      // R1 reset state
      chk("R1", "mode", int'(o_mode[2]), 0);
      chk("R1", "div_shift", int'(o_div[2]), 5);
      chk("R1", "clk_src", int'(o_src[2]), 0);
      chk("R1", "hosc_en", int'(o_hen[2]), 1);
      chk("R1", "pll_en", int'(o_pen[2]), 0);
      chk("R1", "gates", int'(o_cpu[2]) + int'(o_io[2]), 2);
      chk("R1", "err", int'(o_err[2]), 0);

      // R2 every gear code
      for (int g = 0; g < 8; g++) begin
         req(10, g);
         chk("R2", $sformatf("div for gear %0d", g), int'(o_div[2]), ((g <= 4) ? g : 0) + 1);
      end
      req(10, 1);

      // R9 PLL select waits for lock
      req(6, 0);
      chk("R9", "pll_en after on", int'(o_pen[2]), 1);
      req(8, 0);
      chk("R9", "src before lock", int'(o_src[2]), 0);
      idle(6);
      chk("R9", "src after lock", int'(o_src[2]), 2);

      // R6 STOP with PLL powered
      req(5, 0);
      chk("R6", "err on stop", int'(o_err[2]), 1);
      chk("R6", "mode kept", int'(o_mode[2]), 0);
      idle(1);
      chk("R10", "err lasts one cycle", int'(o_err[2]), 0);

      // R7 ordered shutdown
      req(7, 0);
      chk("R7", "off while selected err", int'(o_err[2]), 1);
      chk("R7", "pll kept on", int'(o_pen[2]), 1);
      req(9, 0);
      chk("R7", "src back to osc", int'(o_src[2]), 0);
      req(7, 0);
      chk("R7", "pll off", int'(o_pen[2]), 0);
      chk("R7", "no err", int'(o_err[2]), 0);

      // R4 and R5 standby modes
      req(3, 0);
      chk("R4", "idle2 mode", int'(o_mode[2]), 2);
      chk("R4", "idle2 cpu gate", int'(o_cpu[2]), 0);
      chk("R4", "idle2 io gate", int'(o_io[2]), 1);
      wk();
      chk("R5", "idle2 wake", int'(o_mode[2]), 0);
      req(4, 0);
      chk("R4", "idle1 io gate", int'(o_io[2]), 0);
      wk();
      chk("R5", "idle1 wake", int'(o_mode[2]), 0);
      req(5, 0);
      chk("R4", "stop mode", int'(o_mode[2]), 4);
      chk("R4", "stop hosc off", int'(o_hen[2]), 0);
      chk("R4", "stop losc off", int'(o_len[2]), 0);
      req(1, 0);
      chk("R10", "request in stop", int'(o_err[2]), 1);
      chk("R10", "mode held", int'(o_mode[2]), 4);
      wk();
      chk("R5", "stop waits ready", int'(o_mode[2]), 4);
      chk("R5", "stop wake hosc on", int'(o_hen[2]), 1);
      idle(6);
      chk("R5", "stop resumed", int'(o_mode[2]), 0);

      // R3 SLOW
      req(1, 0);
      chk("R3", "single rejects slow", int'(o_err[0]), 1);
      idle(3);
      chk("R3", "slow mode", int'(o_mode[2]), 1);
      chk("R3", "slow src", int'(o_src[2]), 1);
      chk("R3", "slow div", int'(o_div[2]), 1);
      chk("R3", "single stays normal", int'(o_mode[0]), 0);

      // R8 PLL requests ignored in SLOW
      req(6, 0);
      chk("R8", "pll on ignored err", int'(o_err[2]), 0);
      chk("R8", "pll on ignored", int'(o_pen[2]), 0);
      req(8, 0);
      chk("R8", "select ignored", int'(o_src[2]), 1);
      chk("R8", "select no err", int'(o_err[2]), 0);

      // R5 STOP from SLOW returns to SLOW
      req(5, 0);
      wk();
      idle(6);
      chk("R5", "back to slow", int'(o_mode[2]), 1);
      req(2, 0);
      chk("R3", "normal waits hosc", int'(o_mode[2]), 1);
      idle(6);
      chk("R3", "back to normal", int'(o_mode[2]), 0);

      // R10 unknown codes and request while switching
      req(0, 0);
      chk("R10", "op 0", int'(o_err[2]), 1);
      req(12, 0);
      chk("R10", "op 12", int'(o_err[2]), 1);
      @(negedge clk); req_valid = 1'b1; req_op = 4'd1;
      @(negedge clk); req_op = 4'd3;
      @(negedge clk); req_valid = 1'b0;
      chk("R10", "request while switching", int'(o_err[2]), 1);
      idle(2);
      chk("R10", "switch still completes", int'(o_mode[2]), 1);
      req(2, 0);
      idle(6);
      req(6, 0);
      chk("R10", "single pll request", int'(o_err[0]), 1);
      chk("R10", "dual pll request", int'(o_err[1]), 1);
      chk("R10", "triple pll accepted", int'(o_err[2]), 0);

      // IDLE1 from PLL-driven NORMAL keeps the PLL selection
      req(8, 0);
      idle(6);
      req(4, 0);
      chk("R4", "idle1 from pll", int'(o_mode[2]), 3);
      chk("R9", "pll kept in idle", int'(o_src[2]), 2);
      wk();
      chk("R5", "back to pll normal", int'(o_mode[2]), 0);
      chk("R9", "pll source kept", int'(o_src[2]), 2);
      idle(3);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule